// File: doc/BRIEF.md
# Cascadable presettable 4-bit counter

A synchronous up counter of parameterized width (4 bits by default). A parameter selects binary counting, which wraps after all ones, or decade counting, which wraps after 9. A second parameter selects whether the active-low clear acts at once or at the next rising clock edge. Every state bit changes on the same rising edge. A parallel load copies a data word into the count and overrides both count enables.

There are two count enables. Both must be high for the count to advance. Only `ent_i` also gates the carry output, which is high while the count sits at its terminal value. To build a wider synchronous counter, connect one stage's `carry_o` to the next stage's `ent_i` and share the clock, clear, load and `enp_i` among all stages. With synchronous clear, a decode of the outputs fed back to `clr_ni` shortens the count length.

Top module: `casc_counter`

## Requirements
- R1: With `clr_ni` high, `load_ni` low at a rising edge puts `data_i` into `count_o`, whatever `enp_i` and `ent_i` are.
- R2: With `clr_ni` and `load_ni` high and both `enp_i` and `ent_i` high at a rising edge, `count_o` advances by one.
- R3: With `clr_ni` and `load_ni` high and either enable low at a rising edge, `count_o` keeps its value.
- R4: `carry_o` is high exactly when `ent_i` is high and `count_o` equals the terminal value (15 in binary mode, 9 in decade mode), whatever `enp_i` is.
- R5: In binary mode, counting from 15 gives 0.
- R6: In decade mode, counting from 9 gives 0. After a clear and a load of 7, counting gives 8, 9, 0, 1, 2, 3. A loaded value from 10 to 15 counts up normally, 15 goes to 0, and `carry_o` stays low for 10 to 15.
- R7: In asynchronous-clear mode, `count_o` goes to 0 as soon as `clr_ni` falls, with no clock edge.
- R8: In synchronous-clear mode, `count_o` does not change when `clr_ni` falls. It becomes 0 at the next rising edge with `clr_ni` low, whatever the enables are.
- R9: Clear takes priority over load, and load takes priority over counting.
- R10: When stages are chained carry to `ent_i` with a shared `enp_i`, the joined outputs count as one wide binary value, or as a BCD value in decade mode. The last stage's carry is high only at the all-terminal value with the first stage's `ent_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| clr_ni | input | 1 | Active-low clear (asynchronous or synchronous by parameter) |
| load_ni | input | 1 | Active-low synchronous parallel load |
| data_i | input | W | Value to load |
| enp_i | input | 1 | Count enable that does not affect the carry |
| ent_i | input | 1 | Count enable that also gates the carry |
| count_o | output | W | Current count |
| carry_o | output | 1 | Terminal-count carry, gated by `ent_i` |

## Verification
The clocked properties stay off until `clr_ni` has been seen low at a clock edge, because the count has no defined value before the first clear. The properties on load, count and hold assume that in asynchronous-clear mode any low pulse on `clr_ni` either covers the next sampling edge or does not arrive between the condition and that edge. The bench drives every input on the falling clock edge. The only time it lowers the clear mid-cycle is the directed immediate-clear test, and there it holds the clear low across the following rising edge.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;
  typedef enum logic {CNT_BINARY, CNT_DECADE} cnt_kind_e;
  typedef enum logic {CLR_ASYNC, CLR_SYNC} clr_kind_e;
endpackage

// File: rtl/casc_counter_next.sv
module casc_counter_next
  import casc_counter_pkg::*;
#(
  parameter int        W    = 4,
  parameter cnt_kind_e KIND = CNT_BINARY
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  input  logic         load_ni,
  input  logic         enp_i,
  input  logic         ent_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] inc;

  generate
    if (KIND == CNT_DECADE) begin : g_dec
      localparam logic [W-1:0] WRAP_AT = W'(9);
      // values above 9 simply roll through to all-ones and then 0
      assign inc = (cur_i == WRAP_AT) ? '0 : cur_i + 1'b1;
    end else begin : g_bin
      assign inc = cur_i + 1'b1;
    end
  endgenerate

  always_comb begin
    if (!load_ni)              nxt_o = data_i;
    else if (enp_i && ent_i)   nxt_o = inc;
    else                       nxt_o = cur_i;
  end
endmodule

// File: rtl/casc_counter_reg.sv
module casc_counter_reg
  import casc_counter_pkg::*;
#(
  parameter int        W        = 4,
  parameter clr_kind_e CLR_MODE = CLR_ASYNC
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (CLR_MODE == CLR_ASYNC) begin : g_async
      always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) begin
        if (!clr_ni) q_o <= '0;
        else         q_o <= d_i;
      end
    end
  endgenerate
endmodule

// File: rtl/casc_counter_carry.sv
module casc_counter_carry
  import casc_counter_pkg::*;
#(
  parameter int        W    = 4,
  parameter cnt_kind_e KIND = CNT_BINARY
) (
  input  logic [W-1:0] cur_i,
  input  logic         ent_i,
  output logic         carry_o
);
  localparam logic [W-1:0] TERM = (KIND == CNT_DECADE) ? W'(9) : {W{1'b1}};
  assign carry_o = ent_i && (cur_i == TERM);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_counter_pkg::*;
#(
  parameter int        W        = 4,
  parameter cnt_kind_e KIND     = CNT_BINARY,
  parameter clr_kind_e CLR_MODE = CLR_ASYNC
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         enp_i,
  input  logic         ent_i,
  output logic [W-1:0] count_o,
  output logic         carry_o
);
  logic [W-1:0] nxt;

  casc_counter_next #(.W(W), .KIND(KIND)) u_next (
    .cur_i  (count_o),
    .data_i (data_i),
    .load_ni(load_ni),
    .enp_i  (enp_i),
    .ent_i  (ent_i),
    .nxt_o  (nxt)
  );

  casc_counter_reg #(.W(W), .CLR_MODE(CLR_MODE)) u_reg (
    .clk_i (clk_i),
    .clr_ni(clr_ni),
    .d_i   (nxt),
    .q_o   (count_o)
  );

  casc_counter_carry #(.W(W), .KIND(KIND)) u_carry (
    .cur_i  (count_o),
    .ent_i  (ent_i),
    .carry_o(carry_o)
  );
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk
  import casc_counter_pkg::*;
#(
  parameter int        W        = 4,
  parameter cnt_kind_e KIND     = CNT_BINARY,
  parameter clr_kind_e CLR_MODE = CLR_ASYNC
) (
  input logic         clk_i,
  input logic         clr_ni,
  input logic         load_ni,
  input logic [W-1:0] data_i,
  input logic         enp_i,
  input logic         ent_i,
  input logic [W-1:0] count_o,
  input logic         carry_o
);
  localparam logic [W-1:0] TOP_VAL = (KIND == CNT_DECADE) ? W'(9) : {W{1'b1}};

  function automatic logic [W-1:0] step_of(input logic [W-1:0] v);
    if (KIND == CNT_DECADE && v == W'(9)) return '0;
    return v + 1'b1;
  endfunction

  // count is undefined until a clear has been sampled
  logic armed;
  initial armed = 1'b0;
  always @(posedge clk_i) if (!clr_ni) armed <= 1'b1;

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!armed)
    (clr_ni && !load_ni) |=> (!clr_ni || count_o == $past(data_i))); // R1
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!armed)
    (clr_ni && load_ni && enp_i && ent_i) |=> (!clr_ni || count_o == step_of($past(count_o)))); // R2
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!armed)
    (clr_ni && load_ni && !(enp_i && ent_i)) |=> (!clr_ni || $stable(count_o))); // R3
  AST_CARRY_AT_TOP: assert property (@(posedge clk_i) disable iff (!armed)
    (ent_i && count_o == TOP_VAL) |-> carry_o); // R4
  AST_CARRY_NEEDS_ENT: assert property (@(posedge clk_i) disable iff (!armed)
    !ent_i |-> !carry_o); // R4
  AST_CARRY_OFF_ELSEWHERE: assert property (@(posedge clk_i) disable iff (!armed)
    (count_o != TOP_VAL) |-> !carry_o); // R6

  generate
    if (CLR_MODE == CLR_ASYNC) begin : g_async
      AST_CLEAR_NOW: assert property (@(posedge clk_i) disable iff (!armed)
        !clr_ni |-> count_o == '0); // R7
    end else begin : g_sync
      AST_CLEAR_NEXT: assert property (@(posedge clk_i) disable iff (!armed)
        !clr_ni |=> count_o == '0); // R8
      AST_CLEAR_OVER_LOAD: assert property (@(posedge clk_i) disable iff (!armed)
        (!clr_ni && !load_ni) |=> count_o == '0); // R9
    end
  endgenerate
endmodule

bind casc_counter casc_counter_chk #(.W(W), .KIND(KIND), .CLR_MODE(CLR_MODE)) u_chk (
  .clk_i  (clk_i),
  .clr_ni (clr_ni),
  .load_ni(load_ni),
  .data_i (data_i),
  .enp_i  (enp_i),
  .ent_i  (ent_i),
  .count_o(count_o),
  .carry_o(carry_o)
);

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;
  import casc_counter_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // single stages
  logic       clr_n = 1'b0, load_n = 1'b1, enp = 1'b0, ent = 1'b0;
  logic [3:0] data = '0;
  logic [3:0] cnt_a, cnt_d;
  logic       car_a, car_d;
  // chains
  logic       c_clr_n = 1'b0, c_load_n = 1'b1, c_enp = 1'b0, c_ent = 1'b0;
  logic [7:0] c_bin_d = '0, c_bcd_d = '0;
  logic [3:0] bl_q, bh_q, dl_q, dh_q;
  logic       bl_c, bh_c, dl_c, dh_c;

  casc_counter #(.W(4), .KIND(CNT_BINARY), .CLR_MODE(CLR_ASYNC)) dut_i (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .data_i(data),
    .enp_i(enp), .ent_i(ent), .count_o(cnt_a), .carry_o(car_a));
  casc_counter #(.W(4), .KIND(CNT_DECADE), .CLR_MODE(CLR_SYNC)) u_dec (
    .clk_i(clk), .clr_ni(clr_n), .load_ni(load_n), .data_i(data),
    .enp_i(enp), .ent_i(ent), .count_o(cnt_d), .carry_o(car_d));

  casc_counter #(.W(4), .KIND(CNT_BINARY), .CLR_MODE(CLR_SYNC)) u_bin_lo (
    .clk_i(clk), .clr_ni(c_clr_n), .load_ni(c_load_n), .data_i(c_bin_d[3:0]),
    .enp_i(c_enp), .ent_i(c_ent), .count_o(bl_q), .carry_o(bl_c));
  casc_counter #(.W(4), .KIND(CNT_BINARY), .CLR_MODE(CLR_SYNC)) u_bin_hi (
    .clk_i(clk), .clr_ni(c_clr_n), .load_ni(c_load_n), .data_i(c_bin_d[7:4]),
    .enp_i(c_enp), .ent_i(bl_c), .count_o(bh_q), .carry_o(bh_c));
  casc_counter #(.W(4), .KIND(CNT_DECADE), .CLR_MODE(CLR_ASYNC)) u_bcd_lo (
    .clk_i(clk), .clr_ni(c_clr_n), .load_ni(c_load_n), .data_i(c_bcd_d[3:0]),
    .enp_i(c_enp), .ent_i(c_ent), .count_o(dl_q), .carry_o(dl_c));
  casc_counter #(.W(4), .KIND(CNT_DECADE), .CLR_MODE(CLR_ASYNC)) u_bcd_hi (
    .clk_i(clk), .clr_ni(c_clr_n), .load_ni(c_load_n), .data_i(c_bcd_d[7:4]),
    .enp_i(c_enp), .ent_i(dl_c), .count_o(dh_q), .carry_o(dh_c));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_a = 0, m_d = 0, m_bw = 0, m_dw = 0;

  function automatic int dec_inc(input int v);
    return (v == 9) ? 0 : (v + 1) % 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs already driven; advance one rising edge and compare
  task automatic step(input string tag);
    string ta, td;
    bit cnt_go, c_go;
    cnt_go = enp && ent;
    c_go   = c_enp && c_ent;
    if (tag != "") begin ta = tag; td = tag; end
    else if (!clr_n) begin ta = "R7"; td = "R8"; end
    else if (!load_n) begin ta = "R1"; td = "R1"; end
    else if (cnt_go) begin
      ta = (m_a == 15) ? "R5" : "R2";
      td = (m_d == 9 || m_d == 15) ? "R6" : "R2";
    end else begin ta = "R3"; td = "R3"; end

    if (!clr_n) begin m_a = 0; m_d = 0; end
    else if (!load_n) begin m_a = int'(data); m_d = int'(data); end
    else if (cnt_go) begin m_a = (m_a + 1) % 16; m_d = dec_inc(m_d); end

    if (!c_clr_n) begin m_bw = 0; m_dw = 0; end
    else if (!c_load_n) begin
      m_bw = int'(c_bin_d);
      m_dw = int'(c_bcd_d[7:4]) * 10 + int'(c_bcd_d[3:0]);
    end else if (c_go) begin
      m_bw = (m_bw + 1) % 256;
      m_dw = (m_dw + 1) % 100;
    end

    @(posedge clk); #1;
    check(ta, int'(cnt_a), m_a);
    check(td, int'(cnt_d), m_d);
    check("R4", int'(car_a), int'(ent && m_a == 15));
    check("R4", int'(car_d), int'(ent && m_d == 9));
    check("R10", int'({bh_q, bl_q}), m_bw);
    check("R10", int'(dh_q) * 10 + int'(dl_q), m_dw);
    check("R10", int'(bh_c), int'(c_ent && m_bw == 255));
    check("R10", int'(dh_c), int'(c_ent && m_dw == 99));
    @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic l, input logic [3:0] d,
                       input logic p, input logic t);
    clr_n = c; load_n = l; data = d; enp = p; ent = t;
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    @(negedge clk);
    // reset state, both chains cleared too
    step("");
    step("");
    c_clr_n = 1'b1;

    // R6 sequence: clear, preset 7, count to 3, then inhibit
    drive(1'b0, 1'b1, 4'd0, 1'b1, 1'b1); step("R6");
    drive(1'b1, 1'b0, 4'd7, 1'b0, 1'b0); step("R6");
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step("R6");
    check("R6", int'(cnt_d), 3);
    drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step("R3");
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b0);
    step("R3");

    // R6 out-of-range load counts through to 0 with no carry
    drive(1'b1, 1'b0, 4'd12, 1'b1, 1'b1); step("R6");
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) step("R6");

    // R5 binary wrap, carry with ENP low still follows ENT
    drive(1'b1, 1'b0, 4'd14, 1'b0, 1'b1); step("R1");
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1); step("R2");
    drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b1); step("R4");
    check("R4", int'(car_a), 1);
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1); step("R5");
    check("R5", int'(cnt_a), 0);

    // R9 priorities
    drive(1'b0, 1'b0, 4'd5, 1'b1, 1'b1); step("R9");
    drive(1'b1, 1'b0, 4'd5, 1'b1, 1'b1); step("R9");

    // R7 immediate clear; R8 stage must not move before the edge
    drive(1'b1, 1'b0, 4'd6, 1'b0, 1'b0); step("R1");
    drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
    #(CLK_PERIOD/4);
    clr_n = 1'b0;
    #1;
    check("R7", int'(cnt_a), 0);
    check("R8", int'(cnt_d), 6);
    m_a = 0;
    @(negedge clk);
    step("");
    clr_n = 1'b1;

    // R10 directed wrap of both chains
    c_load_n = 1'b0; c_bin_d = 8'hFE; c_bcd_d = 8'h98; c_enp = 1'b1; c_ent = 1'b1;
    step("");
    c_load_n = 1'b1;
    for (int i = 0; i < 3; i++) step("R10");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      drive(($urandom % 20) != 0, ($urandom % 8) != 0, 4'($urandom),
            ($urandom % 4) != 0, ($urandom % 4) != 0);
      c_clr_n  = ($urandom % 64) != 0;
      c_load_n = ($urandom % 32) != 0;
      c_bin_d  = 8'($urandom);
      c_bcd_d  = {4'($urandom % 10), 4'($urandom % 10)};
      c_enp    = ($urandom % 8) != 0;
      c_ent    = ($urandom % 8) != 0;
      step("");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule